// File: doc/BRIEF.md
# Timer Match Output Controller

A free-running up-counter is compared against four programmable match values. Each comparison owns one output bit. On a match, that bit follows a two-bit action code: it can stay as it is, go low, go high, or invert. The output bits are ordinary state. Software can write them and read them back at any time, and they keep their value whether or not a pin carries them.

Each channel can also be switched into single-edge PWM mode. In that mode the channel's pin shows a waveform that goes high when the count reaches the match value and low after the count passes zero. The action code has no effect in PWM mode. A per-channel pin-select mask decides which channels drive their pins. Channels not marked as pinned by the `PIN_MASK` parameter always drive a low pin. By default channel 3 is unpinned.

Top module: `match_out_ctrl`

## Requirements
- R1: `count` resets to 0. It rises by one on each clock while `cnt_en` is high, wraps from 0xFFFF to 0x0000, and holds while `cnt_en` is low.
- R2: Addresses 0 to 3 hold the match values of channels 0 to 3 and can be read and written. Address 4 is the control word: bits 3:0 are the match bits of channels 0 to 3, and bits 5:4, 7:6, 9:8 and 11:10 are the action codes of channels 0, 1, 2 and 3. Other addresses read 0 and ignore writes. A write shows on `rd_data` and on `match_bits` after the next clock edge.
- R3: After reset, every match value, match bit and action code is 0.
- R4: The action codes are 00 for no change, 01 to clear the bit, 10 to set it and 11 to toggle it. The new bit value appears one cycle after `count` first shows the match value.
- R5: An action is applied once per match event. The event is the first cycle in which count and match value are equal. A count that stays equal does not repeat the action.
- R6: If a control-word write and a match event on the same channel fall in the same cycle, the match action decides that channel's bit.
- R7: `pin_out[i]` is 0 whenever `pin_sel[i]` is 0. The match bit still holds its value and can be read on `match_bits` and through address 4.
- R8: A channel whose `PIN_MASK` bit is 0 (by default channel 3) always drives `pin_out` low. Its match bit still works.
- R9: When `pwm_sel[i]` is set, the action code of channel i has no effect on its match bit. The selected pin goes high one cycle after `count` equals the match value, and goes low one cycle after `count` equals 0. A match value of 0 keeps the pin high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter run enable |
| addr | input | ADDR_W (3) | Register address for read and write |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W (16) | Register write data |
| rd_data | output | DATA_W (16) | Register read data (combinational from `addr`) |
| pin_sel | input | NUM_CH (4) | Per-channel pin function select |
| pwm_sel | input | NUM_CH (4) | Per-channel PWM mode select |
| count | output | CNT_W (16) | Current counter value |
| match_bits | output | NUM_CH (4) | Match bit state of every channel |
| pin_out | output | NUM_CH (4) | Pin drive per channel |

## Verification
The counter, the register writes and the match bits each take effect one clock after the cycle that caused them. `rd_data` and `pin_out` follow their sources in the same cycle. A match bit changes one cycle after `count` shows the match value, and a PWM pin changes one cycle after `count` shows the match value or 0. The bench drives inputs and samples outputs at falling edges. It records the `count` value at each sample point and checks the expected bit state against the value seen one sample earlier, so every check falls on the exact cycle its result is due. The same-cycle collision is staged by holding the counter one step before the match value, then issuing the write in the cycle where the match is first seen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ACT_W = 2;

   typedef enum logic [ACT_W-1:0] {
      ACT_NONE = 2'b00,
      ACT_CLR  = 2'b01,
      ACT_SET  = 2'b10,
      ACT_TGL  = 2'b11
   } match_act_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)  count <= '0;
      else if (en) count <= count + 1'b1;
   end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             val_we,
   input  logic [CNT_W-1:0] val_wd,
   input  logic             bit_we,
   input  logic             bit_wd,
   input  match_act_e       act,
   input  logic             pwm_mode,
   output logic [CNT_W-1:0] val,
   output logic             mbit,
   output logic             pwm_out
);
   logic eq, eq_q, hit, use_act;

   assign eq      = (count == val);
   assign hit     = eq & ~eq_q;
   assign use_act = hit & ~pwm_mode & (act != ACT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val  <= '0;
         eq_q <= 1'b0;
      end else begin
         eq_q <= eq;
         if (val_we) val <= val_wd;
      end
   end

   // match event takes priority over a software write of the bit
   always_ff @(posedge clk) begin
      if (!rst_n) mbit <= 1'b0;
      else if (use_act) begin
         case (act)
            ACT_CLR: mbit <= 1'b0;
            ACT_SET: mbit <= 1'b1;
            ACT_TGL: mbit <= ~mbit;
            default: mbit <= mbit;
         endcase
      end else if (bit_we) mbit <= bit_wd;
   end

   // single-edge PWM: rising at match, falling after zero; match wins at 0
   always_ff @(posedge clk) begin
      if (!rst_n)           pwm_out <= 1'b0;
      else if (eq)          pwm_out <= 1'b1;
      else if (count == '0) pwm_out <= 1'b0;
   end
endmodule

// File: rtl/match_out_ctrl.sv
module match_out_ctrl
   import tmr_pkg::*;
#(
   parameter int          CNT_W    = 16,
   parameter int          NUM_CH   = 4,
   parameter int          ADDR_W   = 3,
   parameter logic [NUM_CH-1:0] PIN_MASK = 4'b0111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  rd_data,
   input  logic [NUM_CH-1:0] pin_sel,
   input  logic [NUM_CH-1:0] pwm_sel,
   output logic [CNT_W-1:0]  count,
   output logic [NUM_CH-1:0] match_bits,
   output logic [NUM_CH-1:0] pin_out
);
   localparam int DATA_W    = CNT_W;
   localparam int CTRL_ADDR = NUM_CH;
   localparam int ACT_LSB   = NUM_CH;

   if (ACT_LSB + ACT_W*NUM_CH > DATA_W) begin : g_chk_width
      $error("control word does not fit in data width");
   end
   if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_chk_addr
      $error("address width too small for channel count");
   end

   logic ctrl_we;
   match_act_e          act_q [NUM_CH];
   logic [CNT_W-1:0]    val   [NUM_CH];
   logic [NUM_CH-1:0]   pwm;

   assign ctrl_we = wr_en && (addr == ADDR_W'(CTRL_ADDR));

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(cnt_en), .count(count)
   );

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_CH; i++) begin
         if (!rst_n)       act_q[i] <= ACT_NONE;
         else if (ctrl_we) act_q[i] <= match_act_e'(wr_data[ACT_LSB + ACT_W*i +: ACT_W]);
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_match_chan #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .count   (count),
         .val_we  (wr_en && (addr == ADDR_W'(i))),
         .val_wd  (wr_data),
         .bit_we  (ctrl_we),
         .bit_wd  (wr_data[i]),
         .act     (act_q[i]),
         .pwm_mode(pwm_sel[i]),
         .val     (val[i]),
         .mbit    (match_bits[i]),
         .pwm_out (pwm[i])
      );
      assign pin_out[i] = PIN_MASK[i] & pin_sel[i] & (pwm_sel[i] ? pwm[i] : match_bits[i]);
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(i)) rd_data = val[i];
      end
      if (addr == ADDR_W'(CTRL_ADDR)) begin
         for (int i = 0; i < NUM_CH; i++) begin
            rd_data[i] = match_bits[i];
            rd_data[ACT_LSB + ACT_W*i +: ACT_W] = act_q[i];
         end
      end
   end
endmodule

// File: rtl/match_out_ctrl_chk.sv
module match_out_ctrl_chk #(
   parameter int          CNT_W    = 16,
   parameter int          NUM_CH   = 4,
   parameter logic [NUM_CH-1:0] PIN_MASK = 4'b0111
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_en,
   input logic              wr_en,
   input logic [NUM_CH-1:0] pin_sel,
   input logic [CNT_W-1:0]  count,
   input logic [NUM_CH-1:0] match_bits,
   input logic [NUM_CH-1:0] pin_out
);
   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> count == $past(count) + 1'b1);

   assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(count));

   assert_pin_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_sel) == '0);

   assert_unpinned_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~PIN_MASK) == '0);

   assert_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !cnt_en && !$past(wr_en) && !$past(cnt_en)) |=> $stable(match_bits));
endmodule

bind match_out_ctrl match_out_ctrl_chk #(
   .CNT_W(CNT_W), .NUM_CH(NUM_CH), .PIN_MASK(PIN_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
   .pin_sel(pin_sel), .count(count), .match_bits(match_bits), .pin_out(pin_out)
);

// File: tb/match_out_ctrl_test.sv
module match_out_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic [2:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [3:0]  pin_sel = '0;
   logic [3:0]  pwm_sel = '0;
   logic [15:0] count;
   logic [3:0]  match_bits;
   logic [3:0]  pin_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   match_out_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .pin_sel(pin_sel), .pwm_sel(pwm_sel),
      .count(count), .match_bits(match_bits), .pin_out(pin_out)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R3 count", 32'(count), 0);
      chk("R3 bits", 32'(match_bits), 0);
      chk("R7 pins", 32'(pin_out), 0);
      for (int i = 0; i < 5; i++) begin
         rd(3'(i), d);
         chk("R3 reg", 32'(d), 0);
      end
   endtask

   task automatic t_regs();
      logic [15:0] d;
      wr(0, 16'h1234); wr(1, 16'hABCD); wr(2, 16'h0F0F); wr(3, 16'hFFFF);
      rd(0, d); chk("R2 val0", 32'(d), 32'h1234);
      rd(1, d); chk("R2 val1", 32'(d), 32'hABCD);
      rd(3, d); chk("R2 val3", 32'(d), 32'hFFFF);
      wr(4, 16'h0FFF);
      rd(4, d); chk("R2 ctrl", 32'(d), 32'h0FFF);
      chk("R2 bits", 32'(match_bits), 32'hF);
      wr(5, 16'hFFFF);
      rd(5, d); chk("R2 unmapped", 32'(d), 0);
      rd(4, d); chk("R2 ctrl kept", 32'(d), 32'h0FFF);
      wr(4, 16'h0000);
      chk("R1 held", 32'(count), 0);
   endtask

   task automatic t_actions();
      // ch0 set, ch1 clear, ch2 toggle, ch3 none; bits start 1110
      for (int i = 0; i < 4; i++) wr(3'(i), 16'd5);
      wr(4, 16'h036E);
      @(negedge clk);
      cnt_en = 1'b1;
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         if (count == 16'd5) chk("R4 not yet", 32'(match_bits), 32'hE);
         if (count == 16'd6) begin
            chk("R4 actions", 32'(match_bits), 32'h9);
            cnt_en = 1'b0;
            break;
         end
      end
      chk("R1 stop", 32'(count), 6);
      @(negedge clk);
      pin_sel = 4'h0;
      #1 chk("R7 gated", 32'(pin_out), 0);
      chk("R7 bits kept", 32'(match_bits), 32'h9);
      pin_sel = 4'hF;
      #1 chk("R8 ch3 low", 32'(pin_out), 32'h1);
   endtask

   task automatic t_once();
      wr(4, 16'h0300);           // ch2 toggle, bits 0
      wr(2, count);              // equal while stopped
      repeat (10) @(negedge clk);
      chk("R5 once", 32'(match_bits), 32'h4);
   endtask

   task automatic t_collide();
      logic [15:0] c;
      c = count;
      wr(4, 16'h0020);           // ch0 set, bits 0
      wr(0, c + 16'd1);
      @(negedge clk);
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
      addr = 3'd4; wr_data = 16'h0020; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R6 match wins", 32'(match_bits[0]), 1);
   endtask

   task automatic t_wrap_pwm();
      logic [15:0] prev;
      wr(4, 16'h00F0);           // ch0,ch1 toggle, bits 0
      wr(0, 16'd0);
      wr(1, 16'd3);
      pwm_sel = 4'h3;
      pin_sel = 4'hF;
      @(negedge clk);
      cnt_en = 1'b1;
      for (int n = 0; n < 70000; n++) begin
         @(negedge clk);
         if (count == 16'hFFFF) break;
      end
      @(negedge clk);
      chk("R1 wrap", 32'(count), 0);
      chk("R9 pin1 at 0", 32'(pin_out[1]), 1);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         prev = count;
         chk("R9 pin1", 32'(pin_out[1]), (prev >= 16'd4) ? 1 : 0);
         chk("R9 pin0 m0", 32'(pin_out[0]), 1);
      end
      chk("R9 act ignored", 32'(match_bits[1:0]), 0);
      cnt_en = 1'b0;
      prev = count;
      repeat (3) @(negedge clk);
      chk("R1 hold", 32'(count), 32'(prev));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_actions();
      t_once();
      t_collide();
      t_wrap_pwm();
      finish_run();
   end
endmodule